// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel that moves data, one transfer unit at a time, between a fixed peripheral data register and incrementing memory addresses, or between two memory regions. Software programs a source address, a destination address, a 24-bit unit count, a channel control word and a global operation word through a small register port. The channel then reads each unit from the source and writes it to the destination. Both accesses go over a request/acknowledge memory bus, and the bus is released after every unit.

A unit can start on its own (auto mode), or each unit can wait for a serial receive-full or transmit-empty request. When the count runs out, the channel raises a done flag and, if enabled, a level end interrupt. When an address is not valid for the unit size, the channel raises an error flag and an error interrupt instead.

Register map (register port address: meaning): 0 source address, 1 destination address, 2 unit count, 3 channel control, 4 global operation. Channel control bits: [0] channel enable, [1] done flag, [2] end interrupt enable, [5:3] unit size code, [6] source increments, [7] destination increments, [11:8] request select. Global operation bits: [0] master enable, [1] NMI flag, [2] address-error flag. Unmapped addresses read as zero.

Top module: `dma_chan`

## Requirements
- R1: A unit may start only while channel enable = 1, master enable = 1, done flag = 0, NMI flag = 0 and address-error flag = 0. If any of these does not hold, no bus request is made.
- R2: With request select 4'b0100 (auto), units start with no peripheral request and run back to back until the count is used up.
- R3: Request select 4'b1011 starts one unit for each cycle in which the idle channel sees rx_full_req high. Request select 4'b1010 does the same with tx_empty_req. The request input that is not selected has no effect.
- R4: Size code 0, 1 or 2 moves one beat of mem_size 0, 1 or 2 (byte, half-word, word). Code 3 moves two word beats and codes 4 to 7 move eight word beats. Each beat reads from the source and then writes the read data to the destination. mem_req goes low for at least one cycle after the last write of every unit.
- R5: An incrementing address advances by the unit size in bytes (1, 2, 4, 8 or 32) after each unit, and within a multi-beat unit beat k uses base+4k. A fixed address never changes and is used for every beat.
- R6: The count register keeps only bits [23:0] of a write, reads back zero-extended, and drops by one after each completed unit.
- R7: When the count reaches zero, the done flag is set and no further unit starts. irq_end is high while done = 1 and end interrupt enable = 1.
- R8: If the source or destination address is misaligned for the unit size, the channel sets the address-error flag without making any bus access. The same applies to a 64-bit unit whose incrementing address lies outside system memory (address bits [31:26] differ from 6'h03). irq_err follows the flag whatever the end interrupt enable is.
- R9: A high nmi input sets the NMI flag. The done, NMI and address-error flags are cleared only by writing 0 to their bit, and writing 1 to them has no effect.
- R10: Clearing the channel enable or the master enable, or an NMI, suspends the channel after the unit in progress. The count and the addresses are held, and the transfer resumes without loss once all R1 conditions hold again.
- R11: After reset every register reads 0, mem_req is 0 and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| nmi | input | 1 | Non-maskable interrupt indication |
| rx_full_req | input | 1 | Serial receive-full request |
| tx_empty_req | input | 1 | Serial transmit-empty request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat address |
| mem_size | output | 2 | Beat size: 0 byte, 1 half-word, 2 word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted at this clock edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack on a read |
| irq_end | output | 1 | Normal end interrupt (level) |
| irq_err | output | 1 | Address-error interrupt (level) |

## Verification
A unit starts on the edge after the idle channel sees a qualified request. The read request shows in the next cycle, and each beat then waits on mem_ack, so the bench logs every write at the falling edge just before the accepting rising edge. The count, the addresses and the done flag change on the edge that takes the last write acknowledge. An address error sets its flag on the edge after the trigger is seen. The bench therefore polls irq_end, or waits a fixed margin of cycles that covers one full unit, before it reads registers at a falling edge.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } dma_st_e;

    localparam logic [3:0] SEL_AUTO = 4'b0100;
    localparam logic [3:0] SEL_RX   = 4'b1011;
    localparam logic [3:0] SEL_TX   = 4'b1010;

    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_CNT  = 3'd2;
    localparam logic [2:0] RA_CTRL = 3'd3;
    localparam logic [2:0] RA_OP   = 3'd4;

endpackage

// File: rtl/dma_step.sv
module dma_step #(
    parameter logic [5:0] SYS_TAG = 6'h03
) (
    input  logic [2:0] size_code,
    input  logic [4:0] src_lo,
    input  logic [4:0] dst_lo,
    input  logic [5:0] src_tag,
    input  logic [5:0] dst_tag,
    input  logic       src_inc,
    input  logic       dst_inc,
    output logic [5:0] unit_bytes,
    output logic [2:0] last_beat,
    output logic [1:0] bus_size,
    output logic       bad
);

    logic [4:0] align_mask;
    logic       misaligned;
    logic       outside_sys;

    always_comb begin
        case (size_code)
            3'd0:    begin unit_bytes = 6'd1;  last_beat = 3'd0; bus_size = 2'd0; align_mask = 5'h00; end
            3'd1:    begin unit_bytes = 6'd2;  last_beat = 3'd0; bus_size = 2'd1; align_mask = 5'h01; end
            3'd2:    begin unit_bytes = 6'd4;  last_beat = 3'd0; bus_size = 2'd2; align_mask = 5'h03; end
            3'd3:    begin unit_bytes = 6'd8;  last_beat = 3'd1; bus_size = 2'd2; align_mask = 5'h07; end
            default: begin unit_bytes = 6'd32; last_beat = 3'd7; bus_size = 2'd2; align_mask = 5'h1f; end
        endcase
        misaligned  = (|(src_lo & align_mask)) || (|(dst_lo & align_mask));
        outside_sys = (size_code == 3'd3) &&
                      ((src_inc && (src_tag != SYS_TAG)) || (dst_inc && (dst_tag != SYS_TAG)));
        bad         = misaligned || outside_sys;
    end

endmodule

// File: rtl/dma_trig.sv
module dma_trig
    import dmac_pkg::*;
(
    input  logic       chan_en,
    input  logic       master_en,
    input  logic       done_flag,
    input  logic       nmi_flag,
    input  logic       aerr_flag,
    input  logic [3:0] req_sel,
    input  logic       rx_req,
    input  logic       tx_req,
    output logic       go
);

    logic qualified;
    logic wanted;

    always_comb begin
        qualified = chan_en && master_en && !done_flag && !nmi_flag && !aerr_flag;
        wanted    = (req_sel == SEL_AUTO) ||
                    ((req_sel == SEL_RX) && rx_req) ||
                    ((req_sel == SEL_TX) && tx_req);
        go        = qualified && wanted;
    end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dmac_pkg::*;
#(
    parameter int         AW      = 32,
    parameter int         CNT_W   = 24,
    parameter logic [5:0] SYS_TAG = 6'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_waddr,
    input  logic [31:0]   reg_wdata,
    input  logic [2:0]    reg_raddr,
    output logic [31:0]   reg_rdata,
    input  logic          nmi,
    input  logic          rx_full_req,
    input  logic          tx_empty_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          irq_end,
    output logic          irq_err
);

    localparam int DW = 32;

    typedef struct packed {
        dma_st_e          st;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             done;
        logic             ie;
        logic [2:0]       sz;
        logic             sinc;
        logic             dinc;
        logic [3:0]       sel;
        logic             men;
        logic             nmif;
        logic             aerr;
        logic [2:0]       beat;
        logic [DW-1:0]    data_hold;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic [5:0]    unit_bytes;
    logic [2:0]    last_beat;
    logic [1:0]    bus_size;
    logic          unit_bad;
    logic          go;
    logic [AW-1:0] beat_off;
    logic [AW-1:0] step_src;
    logic [AW-1:0] step_dst;
    logic          unit_last;

    dma_step #(.SYS_TAG(SYS_TAG)) u_step (
        .size_code (st_q.sz),
        .src_lo    (st_q.src[4:0]),
        .dst_lo    (st_q.dst[4:0]),
        .src_tag   (st_q.src[AW-1:AW-6]),
        .dst_tag   (st_q.dst[AW-1:AW-6]),
        .src_inc   (st_q.sinc),
        .dst_inc   (st_q.dinc),
        .unit_bytes(unit_bytes),
        .last_beat (last_beat),
        .bus_size  (bus_size),
        .bad       (unit_bad)
    );

    dma_trig u_trig (
        .chan_en  (st_q.en),
        .master_en(st_q.men),
        .done_flag(st_q.done),
        .nmi_flag (st_q.nmif),
        .aerr_flag(st_q.aerr),
        .req_sel  (st_q.sel),
        .rx_req   (rx_full_req),
        .tx_req   (tx_empty_req),
        .go       (go)
    );

    always_comb begin
        beat_off  = {{(AW-5){1'b0}}, st_q.beat, 2'b00};
        step_src  = st_q.sinc ? {{(AW-6){1'b0}}, unit_bytes} : '0;
        step_dst  = st_q.dinc ? {{(AW-6){1'b0}}, unit_bytes} : '0;
        unit_last = (st_q.beat == last_beat);

        st_d = st_q;

        // software writes; flags only clear on a written 0
        if (reg_we) begin
            case (reg_waddr)
                RA_SRC:  st_d.src = reg_wdata[AW-1:0];
                RA_DST:  st_d.dst = reg_wdata[AW-1:0];
                RA_CNT:  st_d.cnt = reg_wdata[CNT_W-1:0];
                RA_CTRL: begin
                    st_d.en   = reg_wdata[0];
                    st_d.done = st_q.done & reg_wdata[1];
                    st_d.ie   = reg_wdata[2];
                    st_d.sz   = reg_wdata[5:3];
                    st_d.sinc = reg_wdata[6];
                    st_d.dinc = reg_wdata[7];
                    st_d.sel  = reg_wdata[11:8];
                end
                RA_OP: begin
                    st_d.men  = reg_wdata[0];
                    st_d.nmif = st_q.nmif & reg_wdata[1];
                    st_d.aerr = st_q.aerr & reg_wdata[2];
                end
                default: ;
            endcase
        end

        if (nmi) begin
            st_d.nmif = 1'b1;
        end

        case (st_q.st)
            ST_IDLE: begin
                if (go) begin
                    if (unit_bad) begin
                        st_d.aerr = 1'b1;
                    end else begin
                        st_d.st   = ST_RD;
                        st_d.beat = '0;
                    end
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    st_d.data_hold = mem_rdata;
                    st_d.st        = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    if (unit_last) begin
                        st_d.st  = ST_IDLE;
                        st_d.src = st_q.src + step_src;
                        st_d.dst = st_q.dst + step_dst;
                        st_d.cnt = st_q.cnt - 1'b1;
                        if (st_q.cnt == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                            st_d.done = 1'b1;
                        end
                    end else begin
                        st_d.beat = st_q.beat + 1'b1;
                        st_d.st   = ST_RD;
                    end
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_req   = (st_q.st != ST_IDLE);
        mem_we    = (st_q.st == ST_WR);
        mem_addr  = (st_q.st == ST_WR) ? (st_q.dst + (st_q.dinc ? beat_off : '0))
                                       : (st_q.src + (st_q.sinc ? beat_off : '0));
        mem_size  = bus_size;
        mem_wdata = st_q.data_hold;
        irq_end   = st_q.done && st_q.ie;
        irq_err   = st_q.aerr;
        case (reg_raddr)
            RA_SRC:  reg_rdata = DW'(st_q.src);
            RA_DST:  reg_rdata = DW'(st_q.dst);
            RA_CNT:  reg_rdata = DW'(st_q.cnt);
            RA_CTRL: reg_rdata = {20'd0, st_q.sel, st_q.dinc, st_q.sinc, st_q.sz,
                                  st_q.ie, st_q.done, st_q.en};
            RA_OP:   reg_rdata = {29'd0, st_q.aerr, st_q.nmif, st_q.men};
            default: reg_rdata = '0;
        endcase
    end

    // R1: an idle channel without both enables makes no request next cycle
    p_idle_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_IDLE && !(st_q.en && st_q.men)) |=> !mem_req);

    // R4: an unacknowledged beat holds its address and direction
    p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: bus released after the final write of a unit
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_WR && mem_ack && unit_last) |=> !mem_req);

    // R6: one decrement per completed unit
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_WR && mem_ack && unit_last && !(reg_we && reg_waddr == RA_CNT))
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R7: done appears only with the bus idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> !mem_req);

    // R8: an address error never comes with a bus access
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.aerr) |-> !mem_req);

endmodule

// File: tb/tb_dma_chan.sv
module tb_dma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        nmi = 1'b0;
    logic        rx_full_req = 1'b0;
    logic        tx_empty_req = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq_end;
    logic        irq_err;

    int tests = 0;
    int fails = 0;
    int wcount = 0;
    int req_cycles = 0;
    int rel_bad = 0;
    int rel_pend = 0;
    int cur_beats = 1;
    logic [31:0] log_a [32];
    logic [31:0] log_d [32];
    logic [1:0]  log_s [32];

    always #10 clk = ~clk;

    dma_chan dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .nmi(nmi), .rx_full_req(rx_full_req), .tx_empty_req(tx_empty_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_end(irq_end), .irq_err(irq_err)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic en, input logic dn, input logic ie,
                                            input logic [2:0] sz, input logic si,
                                            input logic di, input logic [3:0] sel);
        return {20'd0, sel, di, si, sz, ie, dn, en};
    endfunction

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_we && !mem_ack) mem_rdata <= pat(mem_addr);
        end
    end

    // write logger, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) req_cycles++;
            if (rel_pend != 0) begin
                if (mem_req) rel_bad++;
                rel_pend = 0;
            end
            if (mem_req && mem_we && mem_ack) begin
                if (wcount < 32) begin
                    log_a[wcount] = mem_addr;
                    log_d[wcount] = mem_wdata;
                    log_s[wcount] = mem_size;
                end
                wcount++;
                if (wcount % cur_beats == 0) rel_pend = 1;
            end
        end
    end

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        report();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_raddr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_log;
        @(posedge clk);
        #2;
        wcount = 0; req_cycles = 0; rel_bad = 0; rel_pend = 0;
    endtask

    task automatic wait_end;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq_end) break;
        end
    endtask

    task automatic pulse_rx;
        @(negedge clk); rx_full_req = 1'b1;
        @(negedge clk); rx_full_req = 1'b0;
    endtask

    task automatic pulse_tx;
        @(negedge clk); tx_empty_req = 1'b1;
        @(negedge clk); tx_empty_req = 1'b0;
    endtask

    task automatic pulse_nmi;
        @(negedge clk); nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
    endtask

    logic [31:0] v;
    logic [31:0] c1;
    int          w1;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R11 register reset", v, 32'd0);
        end
        chk("R11 mem_req reset", {31'd0, mem_req}, 32'd0);
        chk("R11 irq reset", {30'd0, irq_end, irq_err}, 32'd0);

        // R6 upper count bits dropped
        wr(3'd2, 32'hFFAB_CDEF);
        rd(3'd2, v);
        chk("R6 count width", v, 32'h00AB_CDEF);

        // R2/R4/R5/R6/R7 sweep: size x address modes, auto mode, 3 units
        for (int sz = 0; sz < 5; sz++) begin
            for (int md = 0; md < 4; md++) begin
                automatic logic si = md[0];
                automatic logic di = md[1];
                automatic int bytes = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : (sz == 3) ? 8 : 32;
                automatic int beats = (sz == 3) ? 2 : (sz == 4) ? 8 : 1;
                automatic logic [31:0] sb = 32'h0C00_0100;
                automatic logic [31:0] db = 32'h0C00_0800;
                cur_beats = beats;
                wr(3'd3, 32'd0);
                wr(3'd0, sb);
                wr(3'd1, db);
                wr(3'd2, 32'd3);
                wr(3'd4, 32'd1);
                clr_log();
                wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'(sz), si, di, 4'b0100));
                wait_end();
                chk("R4 write beat count", 32'(wcount), 32'(3 * beats));
                for (int u = 0; u < 3; u++) begin
                    for (int k = 0; k < beats; k++) begin
                        automatic int n = u * beats + k;
                        automatic logic [31:0] ea = db + (di ? 32'(u * bytes + k * 4) : 32'd0);
                        automatic logic [31:0] ra = sb + (si ? 32'(u * bytes + k * 4) : 32'd0);
                        chk("R5 write address", log_a[n], ea);
                        chk("R4 dual-address data", log_d[n], pat(ra));
                        chk("R4 beat size", {30'd0, log_s[n]}, (sz < 3) ? 32'(sz) : 32'd2);
                    end
                end
                chk("R4 bus release per unit", 32'(rel_bad), 32'd0);
                rd(3'd0, v);
                chk("R5 final source", v, sb + (si ? 32'(3 * bytes) : 32'd0));
                rd(3'd1, v);
                chk("R5 final destination", v, db + (di ? 32'(3 * bytes) : 32'd0));
                rd(3'd2, v);
                chk("R6 count exhausted", v, 32'd0);
                rd(3'd3, v);
                chk("R7 done flag", {31'd0, v[1]}, 32'd1);
                chk("R7 irq_end", {31'd0, irq_end}, 32'd1);
                wr(3'd3, 32'd0);
                chk("R9 done cleared by 0", {31'd0, irq_end}, 32'd0);
            end
        end

        // R1 gating: master off, then NMI flag, then done flag
        cur_beats = 1;
        wr(3'd0, 32'h0C00_0100);
        wr(3'd1, 32'h0C00_0800);
        wr(3'd2, 32'd2);
        wr(3'd4, 32'd0);
        clr_log();
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 4'b0100));
        idle(20);
        chk("R1 master off no request", 32'(req_cycles), 32'd0);
        pulse_nmi();
        rd(3'd4, v);
        chk("R9 nmi sets flag", {31'd0, v[1]}, 32'd1);
        wr(3'd4, 32'd3);
        idle(20);
        rd(3'd4, v);
        chk("R9 writing 1 keeps nmi flag", v, 32'd3);
        chk("R1 nmi flag blocks", 32'(req_cycles), 32'd0);
        wr(3'd4, 32'd1);
        wait_end();
        chk("R2 auto runs once enabled", 32'(wcount), 32'd2);
        wr(3'd2, 32'd2);
        clr_log();
        idle(20);
        chk("R1 done flag blocks", 32'(req_cycles), 32'd0);
        rd(3'd2, v);
        chk("R1 count held while done", v, 32'd2);

        // R3 peripheral requests
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 4'b1011));
        clr_log();
        idle(10);
        chk("R3 rx mode waits", 32'(req_cycles), 32'd0);
        pulse_tx();
        idle(10);
        chk("R3 tx ignored in rx mode", 32'(wcount), 32'd0);
        pulse_rx();
        idle(10);
        chk("R3 one unit per rx request", 32'(wcount), 32'd1);
        rd(3'd2, v);
        chk("R3 count after rx unit", v, 32'd1);
        wr(3'd2, 32'd2);
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 4'b1010));
        clr_log();
        pulse_rx();
        idle(10);
        chk("R3 rx ignored in tx mode", 32'(wcount), 32'd0);
        pulse_tx();
        idle(10);
        chk("R3 one unit per tx request", 32'(wcount), 32'd1);
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 4'b0000));
        clr_log();
        idle(10);
        chk("R3 unknown select idle", 32'(req_cycles), 32'd0);

        // R8 misaligned source, interrupt enable off
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h0C00_0102);
        wr(3'd1, 32'h0C00_0800);
        wr(3'd2, 32'd4);
        clr_log();
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 4'b0100));
        idle(10);
        rd(3'd4, v);
        chk("R8 address error flag", {31'd0, v[2]}, 32'd1);
        chk("R8 irq_err without ie", {31'd0, irq_err}, 32'd1);
        chk("R8 no bus access", 32'(req_cycles), 32'd0);
        wr(3'd0, 32'h0C00_0100);
        wr(3'd4, 32'd1);
        idle(100);
        chk("R9 error flag cleared by 0", {31'd0, irq_err}, 32'd0);
        rd(3'd2, v);
        chk("R8 resumes after clear", v, 32'd0);

        // R8 64-bit with incrementing address outside system memory
        wr(3'd3, 32'd0);
        wr(3'd1, 32'h0000_0800);
        wr(3'd2, 32'd2);
        clr_log();
        cur_beats = 2;
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 4'b0100));
        idle(10);
        chk("R8 64-bit outside system memory", {31'd0, irq_err}, 32'd1);
        chk("R8 64-bit error no access", 32'(req_cycles), 32'd0);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd1);
        clr_log();
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, 4'b0100));
        wait_end();
        chk("R8 fixed peripheral 64-bit legal", 32'(wcount), 32'd4);
        chk("R5 fixed destination address", log_a[3], 32'h0000_0800);
        chk("R8 no error on legal unit", {31'd0, irq_err}, 32'd0);

        // R10 suspension and resume
        cur_beats = 1;
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h0C00_0100);
        wr(3'd1, 32'h0C00_0800);
        wr(3'd2, 32'd100);
        clr_log();
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 4'b0100));
        idle(15);
        wr(3'd3, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 4'b0100));
        idle(6);
        w1 = wcount;
        rd(3'd2, c1);
        idle(30);
        chk("R10 channel enable off stops", 32'(wcount), 32'(w1));
        rd(3'd2, v);
        chk("R10 count held", v, c1);
        chk("R6 count matches units", c1, 32'(100 - w1));
        wr(3'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 4'b0100));
        idle(15);
        pulse_nmi();
        idle(6);
        w1 = wcount;
        idle(30);
        chk("R10 nmi stops", 32'(wcount), 32'(w1));
        wr(3'd4, 32'd0);
        wr(3'd4, 32'd1);
        wait_end();
        chk("R10 resume without loss", 32'(wcount), 32'd100);
        rd(3'd0, v);
        chk("R10 source after resume", v, 32'h0C00_0100 + 32'd100);

        report();
        $finish;
    end

endmodule